// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Controller

This block moves a programmed number of words between one peripheral and memory over a bus it shares with the CPU. While the CPU owns the bus, it sets up the controller through a small register port: a memory address, a word count, a transfer direction, a mode, and a go command. After that, the controller waits for the peripheral to request service. It then asks the CPU for the bus. Once the CPU hands over the bus, the controller drives the memory address and the read or write strobe itself and acknowledges each word to the peripheral.

There are two transfer modes. In burst mode the controller keeps the bus for the whole block and moves words back to back. In cycle-stealing mode it gives the bus back after every single word and asks for it again for the next one. When the last word has moved, the controller releases the bus and raises a level interrupt. That interrupt stays set until the CPU writes the control register.

Pads are not modelled. A drive-enable output marks the cycles in which the controller is allowed to drive the shared address, data and strobe lines.

Top module: `busdma_ctrl`

## Requirements
- R1: Register offsets on `reg_sel` are as follows. Offset 0 is the memory address and offset 1 is the word count. Offset 2 is the control register. On a write to offset 2, bit 0 is the direction (1 = peripheral to memory, 0 = memory to peripheral), bit 1 selects cycle stealing (0 = burst), and bit 2 is the go command, which is not stored. A read of offset 2 returns direction in bit 0, mode in bit 1, busy in bit 2 and done in bit 3. `reg_rdata` shows the selected register one clock edge after `reg_sel` is applied.
- R2: A register write is ignored while `bus_grant` is high or while a transfer is in progress.
- R3: A go command while the word count is zero is ignored: busy stays 0 and `bus_req` is never raised.
- R4: Once the controller is started, the clock edge that samples `periph_req` high raises `bus_req`. The first word cycle starts at the edge that samples `bus_grant` high. In that cycle `periph_ack`, the strobe and `drv_en` are all high, and `mem_addr` holds the programmed address.
- R5: Each word increments the address register by one and decrements the count by one. After a transfer of N words, the address reads back as start+N and the count reads back as 0.
- R6: In burst mode, `bus_req` is asserted once for the whole transfer. While `periph_req` is high, words move on consecutive cycles. If `periph_req` drops in the middle of a block, the bus stays held, with no strobes, until the request returns.
- R7: In cycle-stealing mode, exactly one word moves per grant and `bus_req` falls right after each word. It rises again only after `bus_grant` has been sampled low and `periph_req` is high. A transfer of N words therefore produces N separate requests.
- R8: Peripheral to memory: `mem_we` is high for the word cycle, and `mem_wdata` is the `per_wdata` value sampled at the edge that starts that word. While `periph_ack` is high, the peripheral must already present its next word.
- R9: Memory to peripheral: `mem_re` is high for the word cycle, and memory answers on `mem_rdata` within that cycle. `per_rdata` holds the word from the cycle after its acknowledge onward.
- R10: At the edge that ends the last word, `bus_req` and `drv_en` fall, and `irq` and the done bit are set.
- R11: A write to the control register clears `irq` and the done bit.
- R12: `drv_en` is high only while `bus_grant` is high. Outside word cycles, `mem_addr`, `mem_wdata` and both strobes are zero.
- R13: After reset, all outputs are low, every register reads 0, and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe from the CPU |
| reg_sel | input | 2 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Registered read data for `reg_sel` |
| periph_req | input | 1 | Peripheral service request |
| periph_ack | output | 1 | Per-word acknowledge to the peripheral |
| per_wdata | input | DW | Word offered by the peripheral |
| per_rdata | output | DW | Word delivered to the peripheral |
| bus_req | output | 1 | Request for bus ownership |
| bus_grant | input | 1 | Bus ownership granted by the CPU |
| drv_en | output | 1 | Shared-bus drive enable |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench's arbiter returns the grant one edge after the request, so a started transfer follows a fixed timeline:
- `bus_req` rises one edge after the request is sampled.
- `bus_grant` rises one edge after `bus_req`.
- The first acknowledge, strobe and address appear one edge after the grant.
- `per_rdata` carries each word one edge after its acknowledge.
- A register read is due one edge after the select.

The bench drives inputs on the falling edge and samples outputs at the next falling edge after the edge that is due. Counts of acknowledges, request rises and memory or sink contents are compared only after the interrupt, once a three-cycle flush has passed.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_REQ,
    ST_XFER,
    ST_HOLD,
    ST_REL
  } seq_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTL_DIR   = 0;
  localparam int CTL_STEAL = 1;
  localparam int CTL_GO    = 2;
endpackage

// File: rtl/busdma_regs.sv
module busdma_regs
  import busdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_sel,
  input  logic [AW-1:0] cpu_wdata,
  input  logic          grant,
  input  logic          busy,
  input  logic          launch,
  input  logic          finish,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          dir_wr,
  output logic          steal,
  output logic          go,
  output logic [AW-1:0] cpu_rdata,
  output logic          irq
);
  localparam int STW = 4;

  logic wr_ok;
  logic done_q;
  logic [STW-1:0] status;

  assign wr_ok  = cpu_we && !grant && !busy;
  assign go     = wr_ok && (cpu_sel == SEL_CTRL) && cpu_wdata[CTL_GO] && (cur_cnt != '0);
  assign status = {done_q, busy, steal, dir_wr};
  assign irq    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      dir_wr   <= 1'b0;
      steal    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (wr_ok && cpu_sel == SEL_ADDR)
        cur_addr <= cpu_wdata;
      else if (launch)
        cur_addr <= cur_addr + AW'(1);

      if (wr_ok && cpu_sel == SEL_CNT)
        cur_cnt <= cpu_wdata[CW-1:0];
      else if (launch)
        cur_cnt <= cur_cnt - CW'(1);

      if (wr_ok && cpu_sel == SEL_CTRL) begin
        dir_wr <= cpu_wdata[CTL_DIR];
        steal  <= cpu_wdata[CTL_STEAL];
        done_q <= 1'b0;
      end else if (finish) begin
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else begin
      case (cpu_sel)
        SEL_ADDR: cpu_rdata <= cur_addr;
        SEL_CNT:  cpu_rdata <= AW'(cur_cnt);
        SEL_CTRL: cpu_rdata <= AW'(status);
        default:  cpu_rdata <= '0;
      endcase
    end
  end

  AST_ZERO_CNT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cpu_sel == SEL_CTRL && cpu_wdata[CTL_GO] && cur_cnt == '0) |=> !busy); // R3
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    finish |=> irq); // R10
  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cpu_sel == SEL_CTRL && !finish) |=> !irq); // R11
endmodule

// File: rtl/busdma_seq.sv
module busdma_seq
  import busdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic dreq,
  input  logic grant,
  input  logic steal,
  input  logic cnt_zero,
  output logic launch,
  output logic finish,
  output logic busy,
  output logic bus_req,
  output logic drv_en
);
  seq_state_t st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (go) nxt = ST_ARM;
      ST_ARM:  if (dreq) nxt = ST_REQ;
      ST_REQ:  if (grant) nxt = ST_XFER;
      ST_XFER: begin
        if (cnt_zero)   nxt = ST_IDLE;
        else if (steal) nxt = ST_REL;
        else if (dreq)  nxt = ST_XFER;
        else            nxt = ST_HOLD;
      end
      ST_HOLD: if (dreq) nxt = ST_XFER;
      ST_REL:  if (!grant) nxt = ST_ARM;
      default: nxt = ST_IDLE;
    endcase
  end

  assign launch = (nxt == ST_XFER);
  assign finish = (st == ST_XFER) && cnt_zero;
  assign busy   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bus_req <= 1'b0;
      drv_en  <= 1'b0;
    end else begin
      st      <= nxt;
      bus_req <= (nxt == ST_REQ) || (nxt == ST_XFER) || (nxt == ST_HOLD);
      drv_en  <= (nxt == ST_XFER) || (nxt == ST_HOLD);
    end
  end

  AST_REQ_NEEDS_DREQ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(dreq)); // R4
  AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !$past(grant)); // R7
  AST_STEAL_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && steal && !cnt_zero) |=> !bus_req); // R7
  AST_BURST_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |=> bus_req); // R6
endmodule

// File: rtl/busdma_bus.sv
module busdma_bus #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          dir_wr,
  input  logic          grant,
  input  logic          drv_en,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          dack,
  output logic [DW-1:0] per_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      dack      <= 1'b0;
      per_rdata <= '0;
    end else begin
      mem_addr  <= launch ? cur_addr : '0;
      mem_wdata <= (launch && dir_wr) ? per_wdata : '0;
      mem_we    <= launch && dir_wr;
      mem_re    <= launch && !dir_wr;
      dack      <= launch;
      if (mem_re)
        per_rdata <= mem_rdata;
    end
  end

  AST_DRV_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> grant); // R12
  AST_ACK_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    dack |-> ((mem_we ^ mem_re) && drv_en)); // R4
  AST_QUIET_OFF_WORD: assert property (@(posedge clk) disable iff (rst)
    !dack |-> (!mem_we && !mem_re && mem_addr == '0)); // R12
endmodule

// File: rtl/busdma_ctrl.sv
module busdma_ctrl
  import busdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          periph_req,
  output logic          periph_ack,
  input  logic [DW-1:0] per_wdata,
  output logic [DW-1:0] per_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          drv_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  logic dir_wr, steal, go, launch, finish, busy;

  busdma_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst(rst), .cpu_we(reg_we), .cpu_sel(reg_sel), .cpu_wdata(reg_wdata),
    .grant(bus_grant), .busy(busy), .launch(launch), .finish(finish),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .dir_wr(dir_wr), .steal(steal), .go(go),
    .cpu_rdata(reg_rdata), .irq(irq)
  );

  busdma_seq seq_i (
    .clk(clk), .rst(rst), .go(go), .dreq(periph_req), .grant(bus_grant), .steal(steal),
    .cnt_zero(cur_cnt == '0), .launch(launch), .finish(finish), .busy(busy),
    .bus_req(bus_req), .drv_en(drv_en)
  );

  busdma_bus #(.AW(AW), .DW(DW)) bus_i (
    .clk(clk), .rst(rst), .launch(launch), .dir_wr(dir_wr), .grant(bus_grant),
    .drv_en(drv_en), .cur_addr(cur_addr), .per_wdata(per_wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .dack(periph_ack), .per_rdata(per_rdata)
  );
endmodule

// File: tb/busdma_ctrl_tb_top.sv
module busdma_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_ADDR = 2'd0;
  localparam logic [1:0] S_CNT  = 2'd1;
  localparam logic [1:0] S_CTRL = 2'd2;

  typedef struct packed {
    logic [7:0]  addr;
    logic [7:0]  cnt;
    logic        dir;
    logic        steal;
    logic [3:0]  gap;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h40, 8'd4, 1'b1, 1'b0, 4'd0, 16'h1100},
    '{8'h90, 8'd5, 1'b0, 1'b0, 4'd0, 16'h0000},
    '{8'h50, 8'd3, 1'b1, 1'b1, 4'd0, 16'h2200},
    '{8'hA0, 8'd3, 1'b0, 1'b1, 4'd0, 16'h0000},
    '{8'h60, 8'd6, 1'b1, 1'b0, 4'd2, 16'h3300},
    '{8'h20, 8'd1, 1'b1, 1'b0, 4'd0, 16'h4400}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic periph_req = 1'b0;
  logic periph_ack;
  logic [DW-1:0] per_wdata, per_rdata;
  logic bus_req, bus_grant, drv_en, mem_we, mem_re, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic arb_grant = 1'b0;
  logic force_grant = 1'b0;
  logic mon_clr = 1'b0;
  logic [15:0] cur_seed = '0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] sink [32];
  int per_idx = 0, sink_n = 0, br_rises = 0, bad_rise = 0, bad_drv = 0;
  logic ack_d = 1'b0, br_d = 1'b0;
  int total = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busdma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .periph_req(periph_req), .periph_ack(periph_ack),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .drv_en(drv_en), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [15:0] memfn(input int i);
    return 16'h5A00 ^ 16'(i * 37);
  endfunction

  assign bus_grant = arb_grant | force_grant;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign per_wdata = cur_seed + 16'(per_idx) + 16'(periph_ack);

  initial for (int i = 0; i < 256; i++) mem[i] = memfn(i);

  always @(posedge clk) begin
    arb_grant <= rst ? 1'b0 : bus_req;
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    ack_d <= periph_ack;
    br_d  <= bus_req;
    if (mon_clr) begin
      per_idx <= 0; sink_n <= 0; br_rises <= 0; bad_rise <= 0; bad_drv <= 0;
    end else begin
      if (periph_ack) per_idx <= per_idx + 1;
      if (ack_d) begin
        sink[sink_n[4:0]] <= per_rdata;
        sink_n <= sink_n + 1;
      end
      if (bus_req && !br_d) br_rises <= br_rises + 1;
      if (bus_req && !br_d && bus_grant) bad_rise <= bad_rise + 1;
      if (drv_en && !bus_grant) bad_drv <= bad_drv + 1;
    end
  end

  task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] sel, output logic [AW-1:0] d);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_irq(input bit keep_req);
    int cyc = 0;
    while (!irq && cyc < 400) begin
      @(negedge clk); periph_req = keep_req; cyc++;
    end
    periph_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int pause = 0, cyc = 0, errs = 0;
    logic [AW-1:0] rd;
    string mtag;
    mtag = v.steal ? "R7" : "R6";
    cur_seed = v.seed;
    clear_mon();
    cpu_write(S_ADDR, AW'(v.addr));
    cpu_write(S_CNT, AW'(v.cnt));
    cpu_write(S_CTRL, AW'({1'b1, v.steal, v.dir}));
    while (!irq && cyc < 400) begin
      @(negedge clk);
      if (v.gap != 0 && per_idx == int'(v.gap) && pause < 3) begin
        periph_req = 1'b0; pause++;
      end else periph_req = 1'b1;
      cyc++;
    end
    periph_req = 1'b0;
    repeat (3) @(negedge clk);
    check_eq(mtag, "acknowledge count", 32'(per_idx), 32'(v.cnt));
    check_eq(mtag, "request assertions", 32'(br_rises), v.steal ? 32'(v.cnt) : 32'd1);
    check_eq("R7", "request rose while granted", 32'(bad_rise), 32'd0);
    check_eq("R12", "drive without grant", 32'(bad_drv), 32'd0);
    for (int k = 0; k < int'(v.cnt); k++) begin
      if (v.dir) begin
        if (mem[(int'(v.addr) + k) % 256] !== v.seed + 16'(k)) errs++;
      end else begin
        if (sink[k] !== memfn(int'(v.addr) + k)) errs++;
      end
    end
    check_eq(v.dir ? "R8" : "R9", "word mismatches", 32'(errs), 32'd0);
    check_eq("R10", "bus released", {30'd0, bus_req, drv_en}, 32'd0);
    check_eq("R10", "irq set", 32'(irq), 32'd1);
    cpu_read(S_ADDR, rd);
    check_eq("R5", "final address", 32'(rd), 32'(v.addr) + 32'(v.cnt));
    cpu_read(S_CNT, rd);
    check_eq("R5", "final count", 32'(rd), 32'd0);
    cpu_read(S_CTRL, rd);
    check_eq("R1", "status done/idle", 32'(rd), 32'(4'b1000 | {2'b00, v.steal, v.dir}));
    cpu_write(S_CTRL, '0);
    @(negedge clk);
    check_eq("R11", "irq cleared by control write", 32'(irq), 32'd0);
  endtask

  initial begin
    logic [AW-1:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check_eq("R13", "outputs after reset",
             {26'd0, bus_req, drv_en, periph_ack, mem_we, mem_re, irq}, 32'd0);
    cpu_read(S_CTRL, rd);
    check_eq("R13", "status after reset", 32'(rd), 32'd0);
    cpu_read(S_ADDR, rd);
    check_eq("R13", "address after reset", 32'(rd), 32'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R4 first-word timing
    cur_seed = 16'h7700;
    clear_mon();
    cpu_write(S_ADDR, 16'h0070);
    cpu_write(S_CNT, 16'd2);
    cpu_write(S_CTRL, 16'h0005);
    @(negedge clk);
    check_eq("R4", "no request before dreq", 32'(bus_req), 32'd0);
    periph_req = 1'b1;
    @(negedge clk);
    check_eq("R4", "request one edge after dreq", 32'(bus_req), 32'd1);
    @(negedge clk);
    check_eq("R4", "no ack in grant cycle", {30'd0, bus_grant, periph_ack}, 32'd2);
    @(negedge clk);
    check_eq("R4", "first word cycle", {29'd0, periph_ack, mem_we, drv_en}, 32'd7);
    check_eq("R4", "first word address", 32'(mem_addr), 32'h70);
    @(negedge clk);
    check_eq("R6", "second word back to back", 32'(mem_addr), 32'h71);
    wait_irq(1'b1);
    check_eq("R8", "timed words written", {mem[8'h70], mem[8'h71]}, {16'h7700, 16'h7701});
    cpu_write(S_CTRL, '0);

    // R3 zero count
    clear_mon();
    cpu_write(S_CNT, '0);
    cpu_write(S_CTRL, 16'h0004);
    periph_req = 1'b1;
    repeat (10) @(negedge clk);
    periph_req = 1'b0;
    check_eq("R3", "no request on zero count", 32'(br_rises), 32'd0);
    cpu_read(S_CTRL, rd);
    check_eq("R3", "not busy on zero count", 32'(rd[2]), 32'd0);

    // R2 writes ignored under grant
    cpu_write(S_ADDR, 16'h0033);
    @(negedge clk); force_grant = 1'b1;
    cpu_write(S_ADDR, 16'h1234);
    @(negedge clk); force_grant = 1'b0;
    cpu_read(S_ADDR, rd);
    check_eq("R2", "address write under grant", 32'(rd), 32'h33);

    // R2 writes ignored while busy
    cur_seed = 16'h6600;
    clear_mon();
    cpu_write(S_ADDR, 16'h0030);
    cpu_write(S_CNT, 16'd1);
    cpu_write(S_CTRL, 16'h0005);
    cpu_write(S_ADDR, 16'h7777);
    cpu_read(S_ADDR, rd);
    check_eq("R2", "address write while busy", 32'(rd), 32'h30);
    cpu_read(S_CTRL, rd);
    check_eq("R2", "busy while armed", 32'(rd[2]), 32'd1);
    wait_irq(1'b1);
    check_eq("R8", "single word after blocked write", 32'(mem[8'h30]), 32'h6600);
    cpu_write(S_CTRL, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL R4 watchdog: actual=hung expected=complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule